// File: doc/BRIEF.md
# Flow-Control Pause Frame Transmitter

This block produces a complete full-duplex flow-control PAUSE frame on request from software. Software writes one configuration word. The word carries a 16-bit pause quantum and a request flag. The block captures the quantum and the station's own MAC address, then waits for the transmit arbiter's grant. Once it has the grant, it streams the frame one byte per accepted beat on a valid/ready interface. Start-of-frame and end-of-frame markers frame the stream.

The block fills in every field itself, in this order:
- the reserved multicast destination 01-80-C2-00-00-01,
- the captured source address,
- the MAC-control EtherType,
- the PAUSE opcode,
- the quantum,
- zero padding up to the 60-byte minimum that precedes the FCS.

The FCS is appended downstream. The block has no input for the local receive-side pause state, so a frame goes out even while the local transmitter is itself being held off by a received pause. A busy output stays high from the accepted request until the last byte is taken.

Top module: `pause_tx_gen`

## Requirements
- R1: After reset, busy and txValid are low and no byte is offered.
- R2: A write with cfgWrEn high, cfgWrData[16] = 1 and busy low is accepted. On the next cycle busy is high and txValid is still low, and cfgWrData[15:0] is held as the pause quantum.
- R3: The frame is 60 bytes. Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 are the source address, stationAddr[47:40] first. Bytes 12-13 are 88 08 and bytes 14-15 are 00 01. Bytes 16-17 are the quantum, most significant byte first. Bytes 18-59 are 00.
- R4: txSof is high only with byte 0, and txEof is high only with byte 59.
- R5: The byte advances only on a cycle where txValid and txReady are both high. While txReady is low, txData, txSof and txEof hold.
- R6: While a request is pending, no byte is offered until txGrant is high. Once the first byte has been offered, txGrant no longer affects the frame.
- R7: busy falls on the cycle after byte 59 is accepted, and txValid then stays low until a new request is accepted.
- R8: A request written while busy is ignored: the frame in flight keeps its quantum and no second frame follows.
- R9: A write with cfgWrData[16] = 0 leaves busy low and starts no frame.
- R10: The source address is sampled when the request is accepted. Later changes on stationAddr do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 17 | Bit 16 = send request, bits 15:0 = pause quantum |
| stationAddr | input | 48 | Local MAC address used as the source field |
| txGrant | input | 1 | Arbiter grant to start the frame |
| busy | output | 1 | Request accepted and frame not yet fully sent |
| txValid | output | 1 | txData holds a frame byte |
| txData | output | 8 | Frame byte |
| txSof | output | 1 | First byte of the frame |
| txEof | output | 1 | Last byte of the frame |
| txReady | input | 1 | Downstream accepts the current byte |

## Verification
The assertions check on every cycle:
- that a stalled byte and its markers hold,
- that exactly 60 beats lie between the start and end markers,
- that busy drops right after the last beat,
- that a pending request never emits a byte without a grant,
- the handling of request writes, with or without the request flag.

Only the bench's scenarios can show the full byte content of the frame under several quanta and addresses. The same goes for the ignored mid-frame request, for address capture at request time, and for correct content under irregular backpressure.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;

  localparam logic [47:0] PAUSE_DEST_MAC = 48'h0180C2000001;
  localparam logic [15:0] MAC_CTRL_TYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture quantum and source address
    logic clrIdx;    // rewind byte index
    logic advIdx;    // step to next byte
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } txState_t;

endpackage

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
  import pause_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqWrite,
  input  logic      txGrant,
  input  logic      txReady,
  input  logic      lastByte,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      sending
);

  txState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqWrite) begin
          strobe.loadReq = 1'b1;
          strobe.clrIdx  = 1'b1;
          stateNext      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (txGrant) stateNext = ST_SEND;
      end
      ST_SEND: begin
        if (txReady) begin
          if (lastByte) stateNext = ST_IDLE;
          else          strobe.advIdx = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign sending = (state == ST_SEND);

endmodule

// File: rtl/pause_tx_dpath.sv
module pause_tx_dpath
  import pause_tx_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  parameter int ADDR_W      = 48,
  parameter int TIME_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [TIME_W-1:0] wrTime,
  input  logic [ADDR_W-1:0] stationAddr,
  output logic [7:0]        byteOut,
  output logic              firstByte,
  output logic              lastByte
);

  localparam int HDR_W     = 2 * ADDR_W + 32 + TIME_W;
  localparam int HDR_BYTES = HDR_W / 8;
  localparam int IDX_W     = $clog2(FRAME_BYTES);

  logic [TIME_W-1:0] quantum;
  logic [ADDR_W-1:0] srcAddr;
  logic [IDX_W-1:0]  byteIdx;
  logic [HDR_W-1:0]  header;
  logic [7:0]        hdrByte [HDR_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quantum <= '0;
      srcAddr <= '0;
    end else if (strobe.loadReq) begin
      quantum <= wrTime;
      srcAddr <= stationAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              byteIdx <= '0;
    else if (strobe.clrIdx) byteIdx <= '0;
    else if (strobe.advIdx) byteIdx <= byteIdx + 1'b1;
  end

  assign header = {PAUSE_DEST_MAC[ADDR_W-1:0], srcAddr, MAC_CTRL_TYPE, PAUSE_OPCODE, quantum};

  // split header into bytes, most significant first
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hdrByte[g] = header[HDR_W-1-8*g -: 8];
  end

  always_comb begin
    byteOut = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (byteIdx == IDX_W'(i)) byteOut = hdrByte[i];
    end
  end

  assign firstByte = (byteIdx == '0);
  assign lastByte  = (byteIdx == IDX_W'(FRAME_BYTES - 1));

endmodule

// File: rtl/pause_tx_gen.sv
module pause_tx_gen
  import pause_tx_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  parameter int ADDR_W      = 48,
  parameter int TIME_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [TIME_W:0]   cfgWrData,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic              txGrant,
  output logic              busy,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txSof,
  output logic              txEof,
  input  logic              txReady
);

  dpStrobe_t strobe;
  logic      firstByte, lastByte, sending;

  pause_tx_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqWrite (cfgWrEn & cfgWrData[TIME_W]),
    .txGrant  (txGrant),
    .txReady  (txReady),
    .lastByte (lastByte),
    .strobe   (strobe),
    .busy     (busy),
    .sending  (sending)
  );

  pause_tx_dpath #(
    .FRAME_BYTES (FRAME_BYTES),
    .ADDR_W      (ADDR_W),
    .TIME_W      (TIME_W)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrTime      (cfgWrData[TIME_W-1:0]),
    .stationAddr (stationAddr),
    .byteOut     (txData),
    .firstByte   (firstByte),
    .lastByte    (lastByte)
  );

  assign txValid = sending;
  assign txSof   = sending & firstByte;
  assign txEof   = sending & lastByte;

endmodule

// File: rtl/pause_tx_chk.sv
module pause_tx_chk #(
  parameter int FRAME_BYTES = 60,
  parameter int TIME_W      = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgWrEn,
  input logic [TIME_W:0] cfgWrData,
  input logic            txGrant,
  input logic            busy,
  input logic            txValid,
  input logic [7:0]      txData,
  input logic            txSof,
  input logic            txEof,
  input logic            txReady
);

  logic [15:0] beatCnt;
  logic        beat;

  assign beat = txValid & txReady;

  always_ff @(posedge clk) begin
    if (!rstN)             beatCnt <= '0;
    else if (beat && txEof) beatCnt <= '0;
    else if (beat)          beatCnt <= beatCnt + 16'd1;
  end

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cfgWrEn && cfgWrData[TIME_W] |=> busy && !txValid);

  // R9
  noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && (!cfgWrEn || !cfgWrData[TIME_W]) |=> !busy);

  // R3
  dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txSof |-> txData == 8'h01);

  // R4
  sof_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txSof |-> beatCnt == 16'd0);

  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    beat && txEof |-> beatCnt == 16'(FRAME_BYTES - 1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txSof) && $stable(txEof));

  // R6
  grant_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !txValid && !txGrant |=> !txValid);

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rstN)
    beat && txEof |=> !busy && !txValid);

  // R7
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy);

endmodule

bind pause_tx_gen pause_tx_chk #(.FRAME_BYTES(FRAME_BYTES), .TIME_W(TIME_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .txGrant   (txGrant),
  .busy      (busy),
  .txValid   (txValid),
  .txData    (txData),
  .txSof     (txSof),
  .txEof     (txEof),
  .txReady   (txReady)
);

// File: tb/pause_tx_gen_test.sv
`timescale 1ns/1ps
module pause_tx_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [16:0] cfgWrData = '0;
  logic [47:0] stationAddr = '0;
  logic        txGrant = 1'b1;
  logic        busy, txValid, txSof, txEof;
  logic [7:0]  txData;
  logic        txReady = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pause_tx_gen uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .stationAddr(stationAddr), .txGrant(txGrant), .busy(busy),
    .txValid(txValid), .txData(txData), .txSof(txSof), .txEof(txEof),
    .txReady(txReady)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int idx, input logic [15:0] q, input logic [47:0] sa);
    logic [47:0] tmp;
    if (idx < 6) begin
      tmp = 48'h0180C2000001 >> (8 * (5 - idx));
      return tmp[7:0];
    end
    if (idx < 12) begin
      tmp = sa >> (8 * (11 - idx));
      return tmp[7:0];
    end
    case (idx)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h00;
      15: return 8'h01;
      16: return q[15:8];
      17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic writeCfg(input bit req, input logic [15:0] q);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = {req, q};
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  // mode 0: always ready, 1: irregular ready, 2: drop grant after first byte,
  // 3: write a new request mid-frame, 4: change stationAddr mid-frame
  task automatic captureFrame(input logic [15:0] q, input logic [47:0] sa, input int mode);
    int idx = 0;
    bit done = 0;
    bit stalled = 0;
    logic [7:0] heldData = '0;
    bit heldSof = 0, heldEof = 0;
    for (int cyc = 0; cyc < 1000 && !done; cyc++) begin
      txReady = (mode == 1) ? ((cyc % 3) != 1) : 1'b1;
      cfgWrEn = 1'b0;
      if (mode == 3 && idx == 10) begin cfgWrEn = 1'b1; cfgWrData = {1'b1, 16'hBEEF}; end
      if (mode == 4 && idx == 3) stationAddr = 48'hDEADBEEF0000;
      #1;
      if (stalled) begin
        // R5 data and markers hold while stalled
        check(txValid && txData == heldData && txSof == heldSof && txEof == heldEof,
              "R5 hold", {txValid, txData}, {1'b1, heldData});
      end
      stalled = 0;
      if (txValid && !txReady) begin
        stalled = 1; heldData = txData; heldSof = txSof; heldEof = txEof;
      end
      if (txValid && txReady) begin
        check(txData == expByte(idx, q, sa), "R3 byte", txData, expByte(idx, q, sa));
        check(txSof == (idx == 0), "R4 sof", txSof, idx == 0);
        check(txEof == (idx == 59), "R4 eof", txEof, idx == 59);
        if (mode == 2 && idx == 0) txGrant = 1'b0;
        if (txEof) done = 1;
        idx++;
      end
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
    check(idx == 60, "R3 length", idx, 60);
    check(!busy && !txValid, "R7 busy clear", {busy, txValid}, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!txValid && !busy, "R7 R8 idle after frame", {busy, txValid}, 0);
    end
    txGrant = 1'b1;
    txReady = 1'b1;
  endtask

  task automatic testReset();
    #1;
    check(!busy && !txValid, "R1 reset", {busy, txValid}, 0);
  endtask

  task automatic testBasic(input logic [15:0] q, input logic [47:0] sa, input int mode);
    stationAddr = sa;
    writeCfg(1'b1, q);
    #1;
    check(busy && !txValid, "R2 accept", {busy, txValid}, 2);
    captureFrame(q, sa, mode);
  endtask

  task automatic testGrantWait();
    txGrant = 1'b0;
    stationAddr = 48'h0A0B0C0D0E0F;
    writeCfg(1'b1, 16'h0777);
    for (int k = 0; k < 8; k++) begin
      #1;
      check(busy && !txValid, "R6 wait for grant", {busy, txValid}, 2);
      @(negedge clk);
    end
    txGrant = 1'b1;
    captureFrame(16'h0777, 48'h0A0B0C0D0E0F, 2);
  endtask

  task automatic testNoReq();
    writeCfg(1'b0, 16'h5555);
    for (int k = 0; k < 6; k++) begin
      #1;
      check(!busy && !txValid, "R9 no request", {busy, txValid}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic(16'h1234, 48'h001122334455, 0);   // R2 R3 R4 R7
    testBasic(16'hFFFF, 48'hF0E1D2C3B4A5, 1);   // R5 backpressure
    testBasic(16'h0000, 48'h665544332211, 0);   // R3 zero quantum
    testGrantWait();                            // R6
    testBasic(16'hA5A5, 48'h123456789ABC, 3);   // R8 request while busy
    testNoReq();                                // R9
    testBasic(16'h0042, 48'h112233445566, 4);   // R10 address captured
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule